// File: doc/BRIEF.md
# Memory Attribute Template Matcher

This block classifies every 32-bit data access address and returns the attributes that govern it. Two programmable logical templates select logical attributes. Each template is a base address with an attribute byte, plus a mask with an enable bit. Both work on 4 Kbyte pages. An address that matches neither template takes its logical attributes from a default register. That register also holds one byte-order bit, and the bit governs every data access, whether or not a template matched.

Separately from the templates, a fixed map splits the address space into eight 512 Mbyte regions. Each region has its own physical attribute byte.

A plain register port programs and reads back all configuration. Lookups flow through a valid/ready stream. An accepted lookup carries an address and a data word. One cycle later the result appears: the hit code, the logical attributes, the region, its physical attributes, the byte-order flag, and the data word. The data word is byte-reversed when big-endian order is set. The result register holds until the consumer takes it. `lk_ready` is high whenever the result register is empty or is being drained in the same cycle. This is the only source of back-pressure toward the producer.

Top module: `mem_attr_matcher`

## Requirements
- R1: After reset, both template enables, every attribute and the byte-order bit are zero, `res_valid` is low and `lk_ready` is high, so the first lookup reports hit code 0 with zero attributes.
- R2: A template matches when `(addr & mask) == (base & mask)` over address bits 31:12. Address bits 11:0 and the low 12 bits of the base and mask registers never influence the match.
- R3: When both templates match, template 0 wins. The hit code is 0 for no match, 1 for template 0 and 2 for template 1, and it never takes the value 3.
- R4: A template whose enable bit (mask register bit 0) is clear never matches.
- R5: With no template hit, `res_lattr` equals the default register's attribute byte (bits 7:0).
- R6: `res_big_endian` equals bit 8 of the default register for every lookup, hit or miss.
- R7: `res_region` equals address bits 31:29, and `res_pattr` equals the physical attribute byte stored at register offset 8 + region.
- R8: When big-endian is set, `res_data` is the input word with byte 0 exchanged with byte 3 and byte 1 exchanged with byte 2. Otherwise it equals the input word.
- R9: A lookup is accepted when `lk_valid` and `lk_ready` are both high, and its result appears with `res_valid` on the next cycle. While `res_valid` is high and `res_ready` is low, `lk_ready` is low and all result outputs stay unchanged.
- R10: Register offsets are: template n base at 2n (bits 31:12 base, bits 7:0 attribute); template n mask at 2n+1 (bits 31:12 mask, bit 0 enable); default at 4 (bits 7:0 attribute, bit 8 big-endian); physical region r at 8+r (bits 7:0). A read returns its data on the cycle after `cfg_re`. Unused bits and offsets 5 to 7 read as zero.
- R11: A lookup accepted in the same cycle as a configuration write is judged against the configuration as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write enable |
| cfg_re | input | 1 | Register read enable |
| cfg_addr | input | 4 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid the cycle after `cfg_re` |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_addr | input | 32 | Access address to classify |
| lk_data | input | 32 | Data word to order |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 2 | 0 none, 1 template 0, 2 template 1 |
| res_lattr | output | 8 | Selected logical attributes |
| res_pattr | output | 8 | Physical attributes of the region |
| res_region | output | 3 | Region index |
| res_big_endian | output | 1 | Byte-order flag in force |
| res_data | output | 32 | Data word after byte ordering |

## Verification
Two events can fall in the same clock cycle.

The first pair is a configuration write and an accepted lookup. The bench provokes it by writing a new default attribute and clearing the big-endian bit in the cycle that accepts a missing address. It then expects the old attribute and swapped data on that result and the new values on the next lookup.

The second pair is the drain of a held result and the acceptance of a new request. The bench provokes it by stalling `res_ready`, presenting a second request, and then releasing. It judges that the first result stayed frozen during the stall and that the second result replaced it exactly one cycle after release.

// File: rtl/mat_pkg.sv
package mat_pkg;
  // width of the hit code for a given template count (code 0 means no hit)
  function automatic int hit_width(input int n_tmpl);
    return $clog2(n_tmpl + 1);
  endfunction
endpackage

// File: rtl/mat_cfg_regs.sv
module mat_cfg_regs #(
  parameter int ADDR_W  = 32,
  parameter int ATTR_W  = 8,
  parameter int PATTR_W = 8,
  parameter int N_TMPL  = 2,
  parameter int N_REG   = 8,
  parameter int GRAN    = 12,
  parameter int OFF_W   = $clog2(2 * N_REG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_re,
  input  logic [OFF_W-1:0]       cfg_addr,
  input  logic [ADDR_W-1:0]      cfg_wdata,
  output logic [ADDR_W-1:0]      cfg_rdata,
  output logic [ADDR_W-GRAN-1:0] tmpl_base [N_TMPL],
  output logic [ADDR_W-GRAN-1:0] tmpl_mask [N_TMPL],
  output logic [ATTR_W-1:0]      tmpl_attr [N_TMPL],
  output logic [N_TMPL-1:0]      tmpl_en,
  output logic [ATTR_W-1:0]      dflt_attr,
  output logic                   big_endian,
  output logic [PATTR_W-1:0]     phys_attr [N_REG]
);
  localparam int DFLT_OFF = 2 * N_TMPL;
  localparam int PHYS_OFF = N_REG;
  localparam int BE_BIT   = ATTR_W;

  logic [ADDR_W-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_TMPL; i++) begin
        tmpl_base[i] <= '0;
        tmpl_mask[i] <= '0;
        tmpl_attr[i] <= '0;
      end
      tmpl_en    <= '0;
      dflt_attr  <= '0;
      big_endian <= 1'b0;
      for (int r = 0; r < N_REG; r++) phys_attr[r] <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < N_TMPL; i++) begin
        if (cfg_addr == OFF_W'(2 * i)) begin
          tmpl_base[i] <= cfg_wdata[ADDR_W-1:GRAN];
          tmpl_attr[i] <= cfg_wdata[ATTR_W-1:0];
        end
        if (cfg_addr == OFF_W'(2 * i + 1)) begin
          tmpl_mask[i] <= cfg_wdata[ADDR_W-1:GRAN];
          tmpl_en[i]   <= cfg_wdata[0];
        end
      end
      if (cfg_addr == OFF_W'(DFLT_OFF)) begin
        dflt_attr  <= cfg_wdata[ATTR_W-1:0];
        big_endian <= cfg_wdata[BE_BIT];
      end
      for (int r = 0; r < N_REG; r++) begin
        if (cfg_addr == OFF_W'(PHYS_OFF + r)) phys_attr[r] <= cfg_wdata[PATTR_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_TMPL; i++) begin
      if (cfg_addr == OFF_W'(2 * i)) begin
        rd_mux[ADDR_W-1:GRAN] = tmpl_base[i];
        rd_mux[ATTR_W-1:0]    = tmpl_attr[i];
      end
      if (cfg_addr == OFF_W'(2 * i + 1)) begin
        rd_mux[ADDR_W-1:GRAN] = tmpl_mask[i];
        rd_mux[0]             = tmpl_en[i];
      end
    end
    if (cfg_addr == OFF_W'(DFLT_OFF)) begin
      rd_mux[ATTR_W-1:0] = dflt_attr;
      rd_mux[BE_BIT]     = big_endian;
    end
    for (int r = 0; r < N_REG; r++) begin
      if (cfg_addr == OFF_W'(PHYS_OFF + r)) rd_mux[PATTR_W-1:0] = phys_attr[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_re) cfg_rdata <= rd_mux;
  end

  // offsets between the default register and the region table hold nothing
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_re) && $past(cfg_addr) > OFF_W'(DFLT_OFF) && $past(cfg_addr) < OFF_W'(PHYS_OFF))
      |-> cfg_rdata == '0); // R10
endmodule

// File: rtl/mat_tmpl_match.sv
module mat_tmpl_match #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8,
  parameter int N_TMPL = 2,
  parameter int GRAN   = 12,
  parameter int HIT_W  = mat_pkg::hit_width(N_TMPL)
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [ADDR_W-GRAN-1:0] tmpl_base [N_TMPL],
  input  logic [ADDR_W-GRAN-1:0] tmpl_mask [N_TMPL],
  input  logic [ATTR_W-1:0]      tmpl_attr [N_TMPL],
  input  logic [N_TMPL-1:0]      tmpl_en,
  input  logic [ATTR_W-1:0]      dflt_attr,
  output logic [N_TMPL-1:0]      hit_vec,
  output logic [HIT_W-1:0]       hit_code,
  output logic [ATTR_W-1:0]      sel_attr
);
  logic [ADDR_W-GRAN-1:0] page;
  assign page = addr[ADDR_W-1:GRAN];

  for (genvar g = 0; g < N_TMPL; g++) begin : g_cmp
    assign hit_vec[g] = tmpl_en[g] &&
                        ((page & tmpl_mask[g]) == (tmpl_base[g] & tmpl_mask[g]));
  end

  // descending walk: the lowest-numbered matching template is written last
  always_comb begin
    hit_code = '0;
    sel_attr = dflt_attr;
    for (int i = N_TMPL - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_code = HIT_W'(i + 1);
        sel_attr = tmpl_attr[i];
      end
    end
  end
endmodule

// File: rtl/mat_byte_order.sv
module mat_byte_order #(
  parameter int DATA_W = 32
) (
  input  logic              swap,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NB = DATA_W / 8;
  logic [DATA_W-1:0] rev;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
  end

  assign dout = swap ? rev : din;
endmodule

// File: rtl/mem_attr_matcher.sv
module mem_attr_matcher #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ATTR_W  = 8,
  parameter int PATTR_W = 8,
  parameter int N_TMPL  = 2,
  parameter int N_REG   = 8,
  parameter int GRAN    = 12,
  parameter int OFF_W   = $clog2(2 * N_REG),
  parameter int RGN_W   = $clog2(N_REG),
  parameter int HIT_W   = mat_pkg::hit_width(N_TMPL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_re,
  input  logic [OFF_W-1:0]   cfg_addr,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  output logic [ADDR_W-1:0]  cfg_rdata,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [ADDR_W-1:0]  lk_addr,
  input  logic [DATA_W-1:0]  lk_data,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [HIT_W-1:0]   res_hit,
  output logic [ATTR_W-1:0]  res_lattr,
  output logic [PATTR_W-1:0] res_pattr,
  output logic [RGN_W-1:0]   res_region,
  output logic               res_big_endian,
  output logic [DATA_W-1:0]  res_data
);
  logic [ADDR_W-GRAN-1:0] tmpl_base [N_TMPL];
  logic [ADDR_W-GRAN-1:0] tmpl_mask [N_TMPL];
  logic [ATTR_W-1:0]      tmpl_attr [N_TMPL];
  logic [N_TMPL-1:0]      tmpl_en;
  logic [ATTR_W-1:0]      dflt_attr;
  logic                   big_endian;
  logic [PATTR_W-1:0]     phys_attr [N_REG];

  logic [N_TMPL-1:0]      hit_vec;
  logic [HIT_W-1:0]       hit_code;
  logic [ATTR_W-1:0]      sel_attr;
  logic [DATA_W-1:0]      ordered;
  logic [RGN_W-1:0]       region;
  logic                   lk_fire;

  mat_cfg_regs #(
    .ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .PATTR_W(PATTR_W),
    .N_TMPL(N_TMPL), .N_REG(N_REG), .GRAN(GRAN), .OFF_W(OFF_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tmpl_base(tmpl_base), .tmpl_mask(tmpl_mask), .tmpl_attr(tmpl_attr),
    .tmpl_en(tmpl_en), .dflt_attr(dflt_attr), .big_endian(big_endian),
    .phys_attr(phys_attr)
  );

  mat_tmpl_match #(
    .ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .N_TMPL(N_TMPL), .GRAN(GRAN), .HIT_W(HIT_W)
  ) u_match (
    .addr(lk_addr), .tmpl_base(tmpl_base), .tmpl_mask(tmpl_mask),
    .tmpl_attr(tmpl_attr), .tmpl_en(tmpl_en), .dflt_attr(dflt_attr),
    .hit_vec(hit_vec), .hit_code(hit_code), .sel_attr(sel_attr)
  );

  mat_byte_order #(.DATA_W(DATA_W)) u_order (
    .swap(big_endian), .din(lk_data), .dout(ordered)
  );

  assign region   = lk_addr[ADDR_W-1 -: RGN_W];
  assign lk_ready = !res_valid || res_ready;
  assign lk_fire  = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_hit        <= '0;
      res_lattr      <= '0;
      res_pattr      <= '0;
      res_region     <= '0;
      res_big_endian <= 1'b0;
      res_data       <= '0;
    end else if (lk_fire) begin
      res_valid      <= 1'b1;
      res_hit        <= hit_code;
      res_lattr      <= sel_attr;
      res_pattr      <= phys_attr[region];
      res_region     <= region;
      res_big_endian <= big_endian;
      res_data       <= ordered;
    end else if (res_ready) begin
      res_valid      <= 1'b0;
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> res_valid); // R9

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_lattr)
      && $stable(res_pattr) && $stable(res_data) && $stable(res_big_endian))); // R9

  AST_HIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_hit <= HIT_W'(N_TMPL)); // R3

  AST_T0_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fire && hit_vec[0]) |=> res_hit == HIT_W'(1)); // R3

  for (genvar g = 0; g < N_TMPL; g++) begin : g_en_chk
    AST_DISABLED_NOHIT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fire |=> (res_hit != HIT_W'(g + 1) || $past(tmpl_en[g]))); // R4
  end
endmodule

// File: tb/sim_mem_attr_matcher.sv
module sim_mem_attr_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        lk_valid = 1'b0, lk_ready;
  logic [31:0] lk_addr = '0, lk_data = '0;
  logic        res_valid, res_ready = 1'b1;
  logic [1:0]  res_hit;
  logic [7:0]  res_lattr, res_pattr;
  logic [2:0]  res_region;
  logic        res_big_endian;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mem_attr_matcher u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr), .lk_data(lk_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_lattr(res_lattr), .res_pattr(res_pattr), .res_region(res_region),
    .res_big_endian(res_big_endian), .res_data(res_data)
  );

  // {addr, data, hit, lattr, region, pattr}; little-endian, both templates on
  localparam logic [84:0] VEC [8] = '{
    {32'h1000_0000, 32'h0102_0304, 2'd1, 8'hA1, 3'd0, 8'h30},
    {32'h1234_5FFF, 32'hDEAD_BEEF, 2'd1, 8'hA1, 3'd0, 8'h30},
    {32'h2234_5ABC, 32'h5566_7788, 2'd2, 8'hB2, 3'd1, 8'h31},
    {32'hE000_0004, 32'h0000_00FF, 2'd0, 8'h5C, 3'd7, 8'h37},
    {32'h8234_5000, 32'hCAFE_F00D, 2'd2, 8'hB2, 3'd4, 8'h34},
    {32'h1FFF_FFFF, 32'h1357_9BDF, 2'd1, 8'hA1, 3'd0, 8'h30},
    {32'h6000_0000, 32'h2468_ACE0, 2'd0, 8'h5C, 3'd3, 8'h33},
    {32'hA234_5FFF, 32'h0F0F_F0F0, 2'd2, 8'hB2, 3'd5, 8'h35}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  // present one request; on return the result registered at the edge is visible
  task automatic look(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_data = d;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 res_valid", {31'd0, res_valid}, 32'd0);
    check("R1 lk_ready", {31'd0, lk_ready}, 32'd1);
    rst_n = 1'b1;
    rd(4'd4, r);
    check("R1 default reg", r, 32'h0);
    look(32'h1000_0000, 32'h1122_3344);
    check("R1 hit after reset", {30'd0, res_hit}, 32'd0);
    check("R1 lattr after reset", {24'd0, res_lattr}, 32'd0);
    check("R1 data order after reset", res_data, 32'h1122_3344);

    // configure
    wr(4'd0, 32'h1000_0FA1);   // low bits other than attribute are dropped
    wr(4'd1, 32'hF000_0FFF);   // enable set, low bits dropped
    wr(4'd2, 32'h1234_50B2);
    wr(4'd3, 32'h0FFF_F001);
    wr(4'd4, 32'h0000_005C);
    for (int k = 0; k < 8; k++) wr(4'(8 + k), 32'h30 + k);

    // R10 readback
    rd(4'd0, r);  check("R10 base0 read", r, 32'h1000_00A1);
    rd(4'd1, r);  check("R10 mask0 read", r, 32'hF000_0001);
    rd(4'd6, r);  check("R10 reserved offset", r, 32'h0);
    rd(4'd9, r);  check("R10 region1 read", r, 32'h31);

    // table walk: R2 R3 R5 R7
    for (int v = 0; v < 8; v++) begin
      look(VEC[v][84:53], VEC[v][52:21]);
      check($sformatf("R9 valid vec%0d", v), {31'd0, res_valid}, 32'd1);
      check($sformatf("R2 R3 hit vec%0d", v), {30'd0, res_hit}, {30'd0, VEC[v][20:19]});
      check($sformatf("R5 lattr vec%0d", v), {24'd0, res_lattr}, {24'd0, VEC[v][18:11]});
      check($sformatf("R7 region vec%0d", v), {29'd0, res_region}, {29'd0, VEC[v][10:8]});
      check($sformatf("R7 pattr vec%0d", v), {24'd0, res_pattr}, {24'd0, VEC[v][7:0]});
      check($sformatf("R8 data vec%0d", v), res_data, VEC[v][52:21]);
    end

    // R6 R8 big-endian for a hit and a miss
    wr(4'd4, 32'h0000_015C);
    look(32'h1000_0000, 32'h1122_3344);
    check("R6 be on hit", {31'd0, res_big_endian}, 32'd1);
    check("R8 swap on hit", res_data, 32'h4433_2211);
    look(32'h6000_0000, 32'hA0B0_C0D0);
    check("R6 be on miss", {31'd0, res_big_endian}, 32'd1);
    check("R8 swap on miss", res_data, 32'hD0C0_B0A0);

    // R4 disable template 0: the shared address falls to template 1
    wr(4'd1, 32'hF000_0000);
    look(32'h1234_5FFF, 32'h0);
    check("R4 falls to t1", {30'd0, res_hit}, 32'd2);
    check("R4 t1 attr", {24'd0, res_lattr}, 32'hB2);
    look(32'h1000_0000, 32'h0);
    check("R4 disabled miss", {30'd0, res_hit}, 32'd0);

    // R11 write and lookup in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd4; cfg_wdata = 32'h0000_0077;
    lk_valid = 1'b1; lk_addr = 32'h6000_0000; lk_data = 32'h0102_0304;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    check("R11 old attr", {24'd0, res_lattr}, 32'h5C);
    check("R11 old order", res_data, 32'h0403_0201);
    look(32'h6000_0000, 32'h0102_0304);
    check("R11 new attr", {24'd0, res_lattr}, 32'h77);
    check("R11 new order", res_data, 32'h0102_0304);

    // R9 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    look(32'hE000_0004, 32'h0000_0001);
    check("R9 stalled valid", {31'd0, res_valid}, 32'd1);
    check("R9 stalled ready", {31'd0, lk_ready}, 32'd0);
    lk_valid = 1'b1; lk_addr = 32'h1000_0000; lk_data = 32'h0000_0002;
    @(negedge clk);
    check("R9 held region", {29'd0, res_region}, 32'd7);
    check("R9 held data", res_data, 32'h0000_0001);
    res_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R9 next result region", {29'd0, res_region}, 32'd0);
    check("R9 next result data", res_data, 32'h0000_0002);
    @(negedge clk);
    check("R9 drained", {31'd0, res_valid}, 32'd0);

    // R10 unused bits read as zero
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, r);  check("R10 default unused bits", r, 32'h0000_01FF);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, r);  check("R10 mask unused bits", r, 32'hFFFF_F001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule